// File: doc/BRIEF.md
# Register-Addressed I2C Master Bridge

This block lets a host processor reach devices on an I2C bus through a few memory-mapped registers. The host first sets the target device address, the register index inside that device, the bus port to use and the read width. A single access to the data register then runs a whole register-addressed I2C transaction. A write sends one byte to the chosen device register. A read returns one byte, or two bytes packed into a 16-bit word.

The host port is a plain synchronous select/write/address/data interface with a ready signal. Register accesses finish in the cycle they are presented. A data-register access is held with ready low until the I2C STOP has been sent. The block has two open-drain SCL/SDA pairs. Only the selected pair ever pulls a line low. The bit rate comes from a parameterised divider of the system clock. Two sticky status bits report where a transaction was refused.

Top module: `i2cb_bridge`

## Requirements
- R1: The host byte addresses are: data 0x410000, device address 0x41000C, register index 0x410010, status 0x410020, port select 0x410100, read width 0x410104. Any other address writes nothing and reads as 0.
- R2: The device address holds 7 bits in host data bits 6:0 and reads back unchanged. The register index, port select and read width are write-only and read as 0.
- R3: A host write to the data register sends START, the device address with R/W=0, the register index, exactly one data byte taken from host bits 7:0, and STOP.
- R4: A host read of the data register sends START, the address with R/W=0, the register index, a repeated START and the address with R/W=1, then receives the data bytes. Every received byte is ACKed except the last, which is NACKed, and STOP follows. With read width 0 (the reset value) one byte is returned in bits 7:0 and bits 15:8 are 0.
- R5: With read width bit 0 set to 1, two bytes are received; the first lands in bits 15:8 and the second in bits 7:0.
- R6: The register index is kept after every transaction and is never incremented.
- R7: Port select bit 0 picks port 0 or 1. Only the selected port drives its lines, the other port never pulls SCL or SDA low, and both ports are released whenever no transaction runs.
- R8: A NACK on either device-address phase sets status bit 0, ends the transaction with STOP, and leaves the device's memory untouched.
- R9: A NACK on the register-index or write-data phase sets status bit 1 and ends the transaction with STOP.
- R10: Both status bits are 0 after reset and are cleared when a new transaction starts.
- R11: A data-register access keeps ready low until STOP has completed. Any other register access is ready in the same cycle.
- R12: While a transaction runs, consecutive rising SCL edges are 4*CLK_DIV system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host access request, held until ready |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W (24) | Host byte address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid with ready |
| hst_ready | output | 1 | Access completes in this cycle |
| scl_oe | output | NPORTS (2) | Pull SCL low, one bit per port |
| sda_oe | output | NPORTS (2) | Pull SDA low, one bit per port |
| sda_in | input | NPORTS (2) | Sensed SDA level per port |

## Verification
Two byte-level device models, one on each port, have distinct addresses. The second location of a 16-bit read is preloaded with a different value, so a swapped byte order or an auto-incremented index gives a wrong word rather than a plausible one. Three refusals are provoked: a wrong device address on a write, the same on a read, and a device that refuses write data. A design that mapped the phases to the wrong status bit, forgot to clear the bits, or skipped STOP (which leaves the next access hung) is caught. A line monitor flags any low level on the unselected port and any SCL period other than four quarter-periods. This exposes a port mux that leaks and a divider that is off by one.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
   localparam logic [23:0] OFF_DATA = 24'h410000;
   localparam logic [23:0] OFF_SADR = 24'h41000C;
   localparam logic [23:0] OFF_RIDX = 24'h410010;
   localparam logic [23:0] OFF_STAT = 24'h410020;
   localparam logic [23:0] OFF_PORT = 24'h410100;
   localparam logic [23:0] OFF_WIDE = 24'h410104;

   localparam logic [1:0] ST_ADDR_NAK = 2'b01;
   localparam logic [1:0] ST_XFER_NAK = 2'b10;

   typedef enum logic [2:0] {
      IT_START,
      IT_RSTART,
      IT_TX,
      IT_RX,
      IT_STOP
   } item_e;
endpackage

// File: rtl/i2cb_engine.sv
module i2cb_engine
   import i2cb_pkg::*;
#(
   parameter int CLK_DIV = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        rd,
   input  logic        wide,
   input  logic [6:0]  sadr,
   input  logic [7:0]  ridx,
   input  logic [7:0]  wdat,
   input  logic        sda_in,
   output logic        busy,
   output logic        done,
   output logic [1:0]  err_set,
   output logic [15:0] rdata,
   output logic        scl_lvl,
   output logic        sda_lvl
);
   localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLK_DIV - 1);
   localparam logic [3:0] ACK_BIT = 4'd8;

   logic [CNT_W-1:0] cnt;
   logic [1:0]  q;
   logic [3:0]  bitn;
   logic [2:0]  stp;
   logic        run, abort, nak, rd_q, wide_q;
   logic [6:0]  sadr_q;
   logic [7:0]  ridx_q, wdat_q;
   logic [15:0] rx_sh;

   item_e       itm;
   logic [7:0]  txb;
   logic        last;
   logic        tick, bit_item;
   logic [2:0]  bsel;

   // transaction script: which item runs at step stp
   always_comb begin
      itm  = IT_STOP;
      txb  = 8'h00;
      last = 1'b1;
      if (!abort) begin
         if (!rd_q) begin
            case (stp)
               3'd0: itm = IT_START;
               3'd1: begin itm = IT_TX; txb = {sadr_q, 1'b0}; end
               3'd2: begin itm = IT_TX; txb = ridx_q; end
               3'd3: begin itm = IT_TX; txb = wdat_q; end
               default: itm = IT_STOP;
            endcase
         end else begin
            case (stp)
               3'd0: itm = IT_START;
               3'd1: begin itm = IT_TX; txb = {sadr_q, 1'b0}; end
               3'd2: begin itm = IT_TX; txb = ridx_q; end
               3'd3: itm = IT_RSTART;
               3'd4: begin itm = IT_TX; txb = {sadr_q, 1'b1}; end
               3'd5: begin itm = IT_RX; last = !wide_q; end
               3'd6: if (wide_q) itm = IT_RX;
               default: itm = IT_STOP;
            endcase
         end
      end
   end

   assign tick     = run && (cnt == CNT_TOP);
   assign bit_item = (itm == IT_TX) || (itm == IT_RX);
   assign bsel     = 3'(4'd7 - bitn);

   // line levels per quarter of the current item (1 = released)
   always_comb begin
      scl_lvl = 1'b1;
      sda_lvl = 1'b1;
      if (run) begin
         case (itm)
            IT_START:  sda_lvl = (q == 2'd0);
            IT_RSTART: begin scl_lvl = (q != 2'd0); sda_lvl = (q < 2'd2); end
            IT_STOP:   begin scl_lvl = (q != 2'd0); sda_lvl = (q >= 2'd2); end
            IT_TX: begin
               scl_lvl = q[0] ^ q[1];
               sda_lvl = (bitn == ACK_BIT) ? 1'b1 : txb[bsel];
            end
            IT_RX: begin
               scl_lvl = q[0] ^ q[1];
               sda_lvl = (bitn == ACK_BIT) ? last : 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0; q <= '0; bitn <= '0; stp <= '0;
         run <= 1'b0; abort <= 1'b0; nak <= 1'b0;
         rd_q <= 1'b0; wide_q <= 1'b0;
         sadr_q <= '0; ridx_q <= '0; wdat_q <= '0;
         rx_sh <= '0; done <= 1'b0; err_set <= '0;
      end else begin
         done    <= 1'b0;
         err_set <= '0;
         if (start && !run) begin
            run <= 1'b1; rd_q <= rd; wide_q <= wide;
            sadr_q <= sadr; ridx_q <= ridx; wdat_q <= wdat;
            cnt <= '0; q <= '0; bitn <= '0; stp <= '0;
            abort <= 1'b0; nak <= 1'b0; rx_sh <= '0;
         end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick) begin
               q <= q + 2'd1;
               if (q == 2'd2) begin
                  if (itm == IT_RX && bitn != ACK_BIT)
                     rx_sh <= {rx_sh[14:0], sda_in};
                  if (itm == IT_TX && bitn == ACK_BIT && sda_in) begin
                     nak     <= 1'b1;
                     err_set <= (stp == 3'd1 || stp == 3'd4) ? ST_ADDR_NAK : ST_XFER_NAK;
                  end
               end
               if (q == 2'd3) begin
                  if (bit_item && bitn != ACK_BIT) begin
                     bitn <= bitn + 4'd1;
                  end else begin
                     bitn  <= '0;
                     stp   <= stp + 3'd1;
                     abort <= abort | nak;
                     if (itm == IT_STOP) begin
                        run  <= 1'b0;
                        done <= 1'b1;
                     end
                  end
               end
            end
         end
      end
   end

   assign busy  = run;
   assign rdata = rx_sh;
endmodule

// File: rtl/i2cb_regs.sv
module i2cb_regs
   import i2cb_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int PSEL_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_sel,
   input  logic              hst_wr,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [15:0]       hst_wdata,
   output logic [15:0]       hst_rdata,
   output logic              hst_ready,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic [15:0]       eng_rdata,
   input  logic [1:0]        err_set,
   output logic              launch,
   output logic              launch_rd,
   output logic [6:0]        sadr,
   output logic [7:0]        ridx,
   output logic [7:0]        wdat,
   output logic              wide,
   output logic [PSEL_W-1:0] psel
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
   localparam logic [ADDR_W-1:0] A_SADR = ADDR_W'(OFF_SADR);
   localparam logic [ADDR_W-1:0] A_RIDX = ADDR_W'(OFF_RIDX);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(OFF_PORT);
   localparam logic [ADDR_W-1:0] A_WIDE = ADDR_W'(OFF_WIDE);

   logic       data_hit;
   logic [1:0] stat;
   logic       unused_hi;

   assign data_hit  = hst_sel && (hst_addr == A_DATA);
   assign launch    = data_hit && !eng_busy && !eng_done;
   assign launch_rd = !hst_wr;
   assign hst_ready = data_hit ? eng_done : hst_sel;
   assign wdat      = hst_wdata[7:0];
   assign unused_hi = ^hst_wdata[15:8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sadr <= '0; ridx <= '0; wide <= 1'b0; psel <= '0; stat <= '0;
      end else begin
         if (hst_sel && hst_wr && !data_hit) begin
            case (hst_addr)
               A_SADR: sadr <= hst_wdata[6:0];
               A_RIDX: ridx <= hst_wdata[7:0];
               A_PORT: psel <= hst_wdata[PSEL_W-1:0];
               A_WIDE: wide <= hst_wdata[0];
               default: ;
            endcase
         end
         if (launch) stat <= '0;
         else        stat <= stat | err_set;
      end
   end

   always_comb begin
      case (hst_addr)
         A_DATA:  hst_rdata = eng_rdata;
         A_SADR:  hst_rdata = {9'd0, sadr};
         A_STAT:  hst_rdata = {14'd0, stat};
         default: hst_rdata = 16'd0;
      endcase
   end
endmodule

// File: rtl/i2cb_portsel.sv
module i2cb_portsel #(
   parameter int NPORTS = 2,
   parameter int PSEL_W = 1
) (
   input  logic [PSEL_W-1:0] psel,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic [NPORTS-1:0] sda_in,
   output logic [NPORTS-1:0] scl_oe,
   output logic [NPORTS-1:0] sda_oe,
   output logic              sda_pick
);
   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      assign scl_oe[p] = (psel == PSEL_W'(p)) && !scl_lvl;
      assign sda_oe[p] = (psel == PSEL_W'(p)) && !sda_lvl;
   end
   assign sda_pick = sda_in[psel];
endmodule

// File: rtl/i2cb_bridge.sv
module i2cb_bridge #(
   parameter int ADDR_W  = 24,
   parameter int NPORTS  = 2,
   parameter int CLK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_sel,
   input  logic              hst_wr,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [15:0]       hst_wdata,
   output logic [15:0]       hst_rdata,
   output logic              hst_ready,
   output logic [NPORTS-1:0] scl_oe,
   output logic [NPORTS-1:0] sda_oe,
   input  logic [NPORTS-1:0] sda_in
);
   localparam int PSEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

   if (CLK_DIV < 2) begin : g_bad_div
      $error("i2cb_bridge: CLK_DIV must be at least 2");
   end
   if (NPORTS < 2 || (1 << PSEL_W) != NPORTS) begin : g_bad_ports
      $error("i2cb_bridge: NPORTS must be a power of two, at least 2");
   end
   if (ADDR_W < 23) begin : g_bad_addr
      $error("i2cb_bridge: ADDR_W too narrow for the register offsets");
   end

   logic              launch, launch_rd, eng_busy, eng_done, wide;
   logic              scl_lvl, sda_lvl, sda_pick;
   logic [6:0]        sadr;
   logic [7:0]        ridx, wdat;
   logic [PSEL_W-1:0] psel;
   logic [1:0]        err_set;
   logic [15:0]       eng_rdata;

   i2cb_regs #(.ADDR_W(ADDR_W), .PSEL_W(PSEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .hst_ready(hst_ready), .eng_busy(eng_busy), .eng_done(eng_done),
      .eng_rdata(eng_rdata), .err_set(err_set), .launch(launch),
      .launch_rd(launch_rd), .sadr(sadr), .ridx(ridx), .wdat(wdat),
      .wide(wide), .psel(psel)
   );

   i2cb_engine #(.CLK_DIV(CLK_DIV)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(launch), .rd(launch_rd), .wide(wide),
      .sadr(sadr), .ridx(ridx), .wdat(wdat), .sda_in(sda_pick),
      .busy(eng_busy), .done(eng_done), .err_set(err_set), .rdata(eng_rdata),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
   );

   i2cb_portsel #(.NPORTS(NPORTS), .PSEL_W(PSEL_W)) u_port (
      .psel(psel), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_pick(sda_pick)
   );
endmodule

module i2cb_bridge_chk #(
   parameter int NPORTS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hst_sel,
   input logic              hst_ready,
   input logic              launch,
   input logic              eng_busy,
   input logic              eng_done,
   input logic [NPORTS-1:0] scl_oe,
   input logic [NPORTS-1:0] sda_oe
);
   // R7
   scl_one_port_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(scl_oe));
   // R7
   sda_one_port_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sda_oe));
   // R7
   idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> (scl_oe == '0 && sda_oe == '0));
   // R11
   launch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (eng_busy && !hst_ready));
   // R11
   busy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && hst_sel) |-> !hst_ready);
   // R3
   end_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eng_busy) |-> eng_done);
endmodule

bind i2cb_bridge i2cb_bridge_chk #(.NPORTS(NPORTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_ready(hst_ready),
   .launch(launch), .eng_busy(eng_busy), .eng_done(eng_done),
   .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2cb_target.sv
module i2cb_target #(
   parameter logic [6:0] ADR = 7'h50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   input  logic mute,
   output logic drv
);
   typedef enum {T_IDLE, T_ADDR, T_REG, T_WDAT, T_RDAT} ts_e;
   logic [7:0] mem [256];
   int         wr_bytes;
   ts_e        st;
   int         bc;
   logic [7:0] sh, txb, ptr;
   logic       ps, pd, rw, ok;

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      wr_bytes = 0; st = T_IDLE; bc = 0; sh = 0; txb = 0; ptr = 0;
      ps = 1'b1; pd = 1'b1; rw = 1'b0; ok = 1'b0; drv = 1'b0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         st = T_IDLE; bc = 0; ps = 1'b1; pd = 1'b1; drv <= 1'b0;
      end else begin
         if (ps && scl && pd && !sda) begin
            st = T_ADDR; bc = 0; wr_bytes = 0; drv <= 1'b0;
         end else if (ps && scl && !pd && sda) begin
            st = T_IDLE; drv <= 1'b0;
         end else if (!ps && scl) begin
            if (st == T_RDAT) begin
               if (bc < 8) bc++;
               else if (sda) st = T_IDLE;
               else begin ptr = ptr + 8'd1; txb = mem[ptr]; bc = 0; end
            end else if (st != T_IDLE && bc < 8) begin
               sh = {sh[6:0], sda}; bc++;
            end
         end else if (ps && !scl) begin
            if (st == T_RDAT) begin
               drv <= (bc < 8) ? !txb[7-bc] : 1'b0;
            end else if (st != T_IDLE && bc == 8) begin
               ok = 1'b1;
               case (st)
                  T_ADDR: begin ok = (sh[7:1] == ADR); rw = sh[0]; end
                  T_REG:  ptr = sh;
                  T_WDAT: begin
                     ok = !mute;
                     if (ok) begin mem[ptr] = sh; wr_bytes++; end
                  end
                  default: ;
               endcase
               drv <= ok;
               bc = 9;
               if (!ok) st = T_IDLE;
            end else if (st != T_IDLE && bc == 9) begin
               bc = 0; drv <= 1'b0;
               case (st)
                  T_ADDR: if (rw) begin
                     st = T_RDAT; txb = mem[ptr]; drv <= !txb[7];
                  end else st = T_REG;
                  T_REG: st = T_WDAT;
                  default: ;
               endcase
            end
         end
         ps = scl; pd = sda;
      end
   end
endmodule

// File: tb/i2cb_bridge_test.sv
`timescale 1ns/1ps
module i2cb_bridge_test;
   localparam int DIV = 4;
   localparam int NP  = 2;
   localparam logic [23:0] A_DATA = 24'h410000, A_SADR = 24'h41000C,
      A_RIDX = 24'h410010, A_STAT = 24'h410020, A_PORT = 24'h410100,
      A_WIDE = 24'h410104;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, hst_sel, hst_wr, hst_ready;
   logic [23:0]   hst_addr;
   logic [15:0]   hst_wdata, hst_rdata;
   logic [NP-1:0] scl_oe, sda_oe, sda_in, scl_line, tdrv, mute;

   assign scl_line = ~scl_oe;
   assign sda_in   = ~(sda_oe | tdrv);

   i2cb_bridge #(.ADDR_W(24), .NPORTS(NP), .CLK_DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .hst_ready(hst_ready), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
   );

   i2cb_target #(.ADR(7'h50)) t0 (.clk(clk), .rst_n(rst_n), .scl(scl_line[0]),
      .sda(sda_in[0]), .mute(mute[0]), .drv(tdrv[0]));
   i2cb_target #(.ADR(7'h2A)) t1 (.clk(clk), .rst_n(rst_n), .scl(scl_line[1]),
      .sda(sda_in[1]), .mute(mute[1]), .drv(tdrv[1]));

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard queues
   typedef struct { string tag; logic [15:0] val; } exp_t;
   exp_t        exp_q[$];
   logic [15:0] got_q[$];

   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0 && got_q.size() > 0) begin
            exp_t e;
            logic [15:0] g;
            e = exp_q.pop_front();
            g = got_q.pop_front();
            chk(e.tag, g, e.val);
         end
      end
   end

   // line monitors: unselected port quiet (R7), SCL period (R12)
   int cur_port = 0, quiet_bad = 0, per_bad = 0, per_cnt = 0, cyc = 0, last_rise = 0;
   bit have_prev = 0;
   logic [NP-1:0] scl_prev = '1;
   always @(posedge clk) begin
      cyc++;
      if (rst_n) begin
         for (int p = 0; p < NP; p++)
            if (p != cur_port && (!scl_line[p] || !sda_in[p])) quiet_bad++;
         if (scl_line[cur_port] && !scl_prev[cur_port]) begin
            if (have_prev) begin
               per_cnt++;
               if (cyc - last_rise != 4*DIV) per_bad++;
            end
            have_prev = 1;
            last_rise = cyc;
         end
      end
      scl_prev = scl_line;
   end

   task automatic hacc(input logic wr, input logic [23:0] a, input logic [15:0] d,
                       output logic [15:0] r, output int lat);
      @(negedge clk);
      if (a == A_DATA) have_prev = 0;
      hst_sel = 1'b1; hst_wr = wr; hst_addr = a; hst_wdata = d; lat = 0;
      #1;
      while (!hst_ready) begin @(negedge clk); #1; lat++; end
      r = hst_rdata;
      @(negedge clk);
      hst_sel = 1'b0; hst_wr = 1'b0;
   endtask

   task automatic wr_reg(input logic [23:0] a, input logic [15:0] d);
      logic [15:0] r;
      int l;
      hacc(1'b1, a, d, r, l);
   endtask

   task automatic expect_rd(input logic [23:0] a, input logic [15:0] e, input string tag);
      logic [15:0] r;
      int l;
      exp_t it;
      it.tag = tag; it.val = e;
      exp_q.push_back(it);
      hacc(1'b0, a, 16'h0, r, l);
      got_q.push_back(r);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL R11 watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      int lat;
      rst_n = 1'b0; hst_sel = 0; hst_wr = 0; hst_addr = 0; hst_wdata = 0; mute = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R7 reset scl released", {14'd0, scl_line}, 16'h0003);
      chk("R7 reset sda released", {14'd0, sda_in}, 16'h0003);
      expect_rd(A_STAT, 16'h0000, "R10 status after reset");
      expect_rd(A_SADR, 16'h0000, "R2 device address after reset");

      // register file
      wr_reg(A_SADR, 16'hFF50);
      expect_rd(A_SADR, 16'h0050, "R1 R2 device address readback");
      hacc(1'b1, A_RIDX, 16'h0012, r, lat);
      chk("R11 register write ready at once", 16'(lat), 16'd0);
      expect_rd(A_RIDX, 16'h0000, "R2 register index write-only");
      expect_rd(24'h410004, 16'h0000, "R1 unmapped reads zero");

      // single-byte write on port 0
      hacc(1'b1, A_DATA, 16'h33A5, r, lat);
      chk("R11 data write held until STOP", 16'(lat > 4*DIV*29), 16'd1);
      chk("R3 byte stored in device", {8'd0, t0.mem[8'h12]}, 16'h00A5);
      chk("R3 exactly one data byte", 16'(t0.wr_bytes), 16'd1);
      expect_rd(A_STAT, 16'h0000, "R10 clean write status");

      // reads, index kept
      t0.mem[8'h13] = 8'h5A;
      expect_rd(A_DATA, 16'h00A5, "R4 single byte read");
      expect_rd(A_DATA, 16'h00A5, "R6 index not incremented");
      t0.mem[8'h20] = 8'h12;
      t0.mem[8'h21] = 8'h34;
      wr_reg(A_RIDX, 16'h0020);
      wr_reg(A_WIDE, 16'h0001);
      expect_rd(A_WIDE, 16'h0000, "R2 width write-only");
      expect_rd(A_DATA, 16'h1234, "R5 two byte read order");
      wr_reg(A_WIDE, 16'h0000);
      expect_rd(A_DATA, 16'h0012, "R6 R4 index kept after wide read");

      // port 1
      cur_port = 1;
      wr_reg(A_PORT, 16'h0001);
      expect_rd(A_PORT, 16'h0000, "R2 port select write-only");
      wr_reg(A_SADR, 16'h002A);
      wr_reg(A_RIDX, 16'h0005);
      wr_reg(A_DATA, 16'h0077);
      chk("R7 selected port device written", {8'd0, t1.mem[8'h05]}, 16'h0077);
      chk("R7 other port device untouched", {8'd0, t0.mem[8'h05]}, 16'h0000);

      // address refused on write
      wr_reg(A_SADR, 16'h0033);
      wr_reg(A_DATA, 16'h0011);
      expect_rd(A_STAT, 16'h0001, "R8 address NACK on write");
      chk("R8 device memory unchanged", {8'd0, t1.mem[8'h05]}, 16'h0077);
      // address refused on read
      wr_reg(A_WIDE, 16'h0001);
      hacc(1'b0, A_DATA, 16'h0, r, lat);
      expect_rd(A_STAT, 16'h0001, "R8 address NACK on read");
      wr_reg(A_WIDE, 16'h0000);

      // good read clears the flags
      wr_reg(A_SADR, 16'h002A);
      expect_rd(A_DATA, 16'h0077, "R4 port 1 read");
      expect_rd(A_STAT, 16'h0000, "R10 status cleared by new cycle");

      // data refused
      mute[1] = 1'b1;
      wr_reg(A_DATA, 16'h0099);
      mute[1] = 1'b0;
      expect_rd(A_STAT, 16'h0002, "R9 data NACK");
      chk("R9 refused byte not stored", {8'd0, t1.mem[8'h05]}, 16'h0077);
      expect_rd(A_DATA, 16'h0077, "R9 bus usable after abort");

      @(negedge clk);
      @(negedge clk);
      chk("R7 unselected port stayed released", 16'(quiet_bad), 16'd0);
      chk("R12 SCL period", 16'(per_bad), 16'd0);
      chk("R12 periods measured", 16'(per_cnt > 100), 16'd1);
      chk("R7 idle lines released", {14'd0, scl_line & sda_in}, 16'h0003);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule